// File: doc/BRIEF.md
# Per-Channel DMA Interrupt and Enable Register Block

This block holds the channel-enable bits and the interrupt bookkeeping for an eight-channel DMA engine. Each channel reports five kinds of event: end of a whole chained transfer, end of one block, a source-side transaction, a destination-side transaction, and a bus error response. For each kind there is a latched raw word, a mask word, a status word (raw gated by mask) and a write-one-to-clear port. One combined output interrupt tells the processor that some unmasked event is pending.

Software reaches the block over a simple single-cycle register bus. The channel-enable and mask words use a per-bit write-enable field in the upper byte of the written data, so one channel can be changed without a read-modify-write race against another agent. A channel's enable bit drops by itself when that channel's chained transfer finishes.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset every raw, mask, channel-enable and global-enable bit is zero, every readable register reads zero and `irq_o` is low.
- R2: A high bit n on an event input sets raw bit n of that class at the next clock edge, whatever the mask. The bit then stays set until it is cleared. Raw words read at 0x2c0 + 8·k in bits 7:0, where class k = 0 transfer complete, 1 block complete, 2 source transaction, 3 destination transaction, 4 bus error.
- R3: The status word of class k at 0x2e8 + 8·k reads raw AND mask in bits 7:0.
- R4: A write to 0x338 + 8·k clears each raw bit of class k whose data bit (7:0) is 1. The clear word reads zero. If an event and a clear reach the same bit in one cycle, the bit ends up set.
- R5: A write to the mask of class k at 0x310 + 8·k changes mask bit n only when data bit n+8 is 1; the mask reads back in bits 7:0 and bits 31:8 read zero.
- R6: The channel-enable word at 0x3a0 uses the same write-enable scheme (data bits 15:8 select which of bits 7:0 are written) and reads back with bits 31:8 zero.
- R7: A transfer-complete event on channel n clears channel-enable bit n at the next edge, even if a write sets that bit in the same cycle.
- R8: The summary word at 0x360 has bit k set when any status bit of class k is set; bits 31:5 read zero.
- R9: Bit 0 of the word at 0x398 is the global enable. `irq_o` is high exactly when the global enable is set and any summary bit is set.
- R10: Read data appears on `bus_rdata` in the cycle after the read is accepted. Reads of unmapped addresses return zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ev_xfer_done | input | 8 | Per-channel chained-transfer-complete pulses |
| ev_block_done | input | 8 | Per-channel block-complete pulses |
| ev_src_txn | input | 8 | Per-channel source-transaction pulses |
| ev_dst_txn | input | 8 | Per-channel destination-transaction pulses |
| ev_bus_err | input | 8 | Per-channel bus-error pulses |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every stored bit here is visible through a read one cycle later, so a wrong raw, mask or enable bit shows as a wrong readback at the first read of that word. Through the status and summary words it also shows on `irq_o` straight away, with no pipeline in between. The same-cycle collisions (event against clear, completion against enabling write) leave a bit whose final value can be read on the next access. A lost event or a late self-clear is therefore caught two cycles after the stimulus. Writes with a partial or empty write-enable field are read back whole, so a bit changed without its enable bit shows directly.

// File: rtl/chirq_pkg.sv
package chirq_pkg;

  localparam int unsigned NUM_CLASS    = 5;
  localparam int unsigned ADDR_W       = 10;
  localparam int unsigned CLASS_STRIDE = 8;

  // Software-visible offsets: the class order and stride are decoded by drivers.
  localparam logic [ADDR_W-1:0] RAW_BASE  = 10'h2c0;
  localparam logic [ADDR_W-1:0] STAT_BASE = 10'h2e8;
  localparam logic [ADDR_W-1:0] MASK_BASE = 10'h310;
  localparam logic [ADDR_W-1:0] CLR_BASE  = 10'h338;
  localparam logic [ADDR_W-1:0] SUMM_ADDR = 10'h360;
  localparam logic [ADDR_W-1:0] GCFG_ADDR = 10'h398;
  localparam logic [ADDR_W-1:0] CHEN_ADDR = 10'h3a0;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAW,
    RG_STAT,
    RG_MASK,
    RG_CLR,
    RG_SUMM,
    RG_GCFG,
    RG_CHEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] cls;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.kind = RG_NONE;
    s.cls  = '0;
    for (int k = 0; k < NUM_CLASS; k++) begin
      if (a == RAW_BASE + ADDR_W'(k * CLASS_STRIDE)) begin
        s.kind = RG_RAW;  s.cls = 3'(k);
      end
      if (a == STAT_BASE + ADDR_W'(k * CLASS_STRIDE)) begin
        s.kind = RG_STAT; s.cls = 3'(k);
      end
      if (a == MASK_BASE + ADDR_W'(k * CLASS_STRIDE)) begin
        s.kind = RG_MASK; s.cls = 3'(k);
      end
      if (a == CLR_BASE + ADDR_W'(k * CLASS_STRIDE)) begin
        s.kind = RG_CLR;  s.cls = 3'(k);
      end
    end
    if (a == SUMM_ADDR) s.kind = RG_SUMM;
    if (a == GCFG_ADDR) s.kind = RG_GCFG;
    if (a == CHEN_ADDR) s.kind = RG_CHEN;
    return s;
  endfunction

endpackage

// File: rtl/chirq_rst_sync.sv
module chirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign rst_sync_n = stg_q[STAGES-1];

endmodule

// File: rtl/chirq_wemask_reg.sv
// Register whose bits are written only where the upper half of the data
// carries a write-enable; a kill vector forces bits low and overrides writes.
module chirq_wemask_reg #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [2*W-1:0] data_i,
  input  logic [W-1:0]   kill_i,
  output logic [W-1:0]   q_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] bit_we;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    bit_we = data_i[2*W-1:W] & {W{wr_i}};
    q_d    = ((q_r & ~bit_we) | (data_i[W-1:0] & bit_we)) & ~kill_i;
    q_en   = wr_i | (|(q_r & kill_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/chirq_class.sv
// One interrupt class: raw latch (event beats clear), write-enabled mask, status.
module chirq_class #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   ev_i,
  input  logic           clr_wr_i,
  input  logic           mask_wr_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0]   raw_o,
  output logic [W-1:0]   mask_o,
  output logic [W-1:0]   stat_o
);

  logic [W-1:0] raw_q;
  logic [W-1:0] raw_d;
  logic [W-1:0] clr_bits;
  logic         raw_en;
  logic [W-1:0] mask_q;

  always_comb begin
    clr_bits = wdata_i[W-1:0] & {W{clr_wr_i}};
    raw_d    = (raw_q & ~clr_bits) | ev_i;
    raw_en   = clr_wr_i | (|ev_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  chirq_wemask_reg #(.W(W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mask_wr_i),
    .data_i (wdata_i),
    .kill_i ({W{1'b0}}),
    .q_o    (mask_q)
  );

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign stat_o = raw_q & mask_q;

endmodule

// File: rtl/chirq_regbus.sv
// Address decode, write strobes and registered read mux.
module chirq_regbus
  import chirq_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_i,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CLASS-1:0][NCH-1:0] raw_i,
  input  logic [NUM_CLASS-1:0][NCH-1:0] mask_i,
  input  logic [NUM_CLASS-1:0][NCH-1:0] stat_i,
  input  logic [NUM_CLASS-1:0]          summ_i,
  input  logic                          gen_i,
  input  logic [NCH-1:0]                chen_i,
  output logic [NUM_CLASS-1:0]          clr_wr_o,
  output logic [NUM_CLASS-1:0]          mask_wr_o,
  output logic                          chen_wr_o,
  output logic                          gcfg_wr_o,
  output logic [DATA_W-1:0]             rdata_o
);

  reg_sel_t          dec;
  logic              wr_hit;
  logic              rd_en;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    dec    = decode_addr(addr_i);
    wr_hit = sel_i & wr_i;
    rd_en  = sel_i & ~wr_i;
  end

  always_comb begin
    clr_wr_o  = '0;
    mask_wr_o = '0;
    for (int k = 0; k < NUM_CLASS; k++) begin
      if (dec.cls == 3'(k)) begin
        clr_wr_o[k]  = wr_hit && (dec.kind == RG_CLR);
        mask_wr_o[k] = wr_hit && (dec.kind == RG_MASK);
      end
    end
    chen_wr_o = wr_hit && (dec.kind == RG_CHEN);
    gcfg_wr_o = wr_hit && (dec.kind == RG_GCFG);
  end

  always_comb begin
    rd_d = '0;
    case (dec.kind)
      RG_RAW: begin
        for (int k = 0; k < NUM_CLASS; k++) begin
          if (dec.cls == 3'(k)) rd_d[NCH-1:0] = raw_i[k];
        end
      end
      RG_STAT: begin
        for (int k = 0; k < NUM_CLASS; k++) begin
          if (dec.cls == 3'(k)) rd_d[NCH-1:0] = stat_i[k];
        end
      end
      RG_MASK: begin
        for (int k = 0; k < NUM_CLASS; k++) begin
          if (dec.cls == 3'(k)) rd_d[NCH-1:0] = mask_i[k];
        end
      end
      RG_SUMM: rd_d[NUM_CLASS-1:0] = summ_i;
      RG_GCFG: rd_d[0]             = gen_i;
      RG_CHEN: rd_d[NCH-1:0]       = chen_i;
      default: rd_d                = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chirq_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    ev_xfer_done,
  input  logic [NCH-1:0]    ev_block_done,
  input  logic [NCH-1:0]    ev_src_txn,
  input  logic [NCH-1:0]    ev_dst_txn,
  input  logic [NCH-1:0]    ev_bus_err,
  output logic              irq_o
);

  localparam int unsigned WE_W = 2 * NCH;

  logic                          rst_sync_n;
  logic [NUM_CLASS-1:0][NCH-1:0] ev_bus;
  logic [NUM_CLASS-1:0][NCH-1:0] raw_q;
  logic [NUM_CLASS-1:0][NCH-1:0] mask_q;
  logic [NUM_CLASS-1:0][NCH-1:0] stat_w;
  logic [NUM_CLASS-1:0]          summ_w;
  logic [NUM_CLASS-1:0]          clr_wr;
  logic [NUM_CLASS-1:0]          mask_wr;
  logic                          chen_wr;
  logic                          gcfg_wr;
  logic [NCH-1:0]                chen_q;
  logic                          glb_en_q;
  logic                          glb_en_d;

  chirq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Class order is fixed by the register map: transfer, block, src, dst, error.
  assign ev_bus = {ev_bus_err, ev_dst_txn, ev_src_txn, ev_block_done, ev_xfer_done};

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
    chirq_class #(.W(NCH)) u_class (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ev_i      (ev_bus[k]),
      .clr_wr_i  (clr_wr[k]),
      .mask_wr_i (mask_wr[k]),
      .wdata_i   (bus_wdata[WE_W-1:0]),
      .raw_o     (raw_q[k]),
      .mask_o    (mask_q[k]),
      .stat_o    (stat_w[k])
    );
    assign summ_w[k] = |stat_w[k];
  end

  // Channel enables: a finished chain kills its bit, winning over a write.
  chirq_wemask_reg #(.W(NCH)) u_chen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (chen_wr),
    .data_i (bus_wdata[WE_W-1:0]),
    .kill_i (ev_xfer_done),
    .q_o    (chen_q)
  );

  always_comb begin
    glb_en_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      glb_en_q <= 1'b0;
    end else if (gcfg_wr) begin
      glb_en_q <= glb_en_d;
    end
  end

  chirq_regbus #(.NCH(NCH), .DATA_W(DATA_W)) u_regbus (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_i     (bus_sel),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .raw_i     (raw_q),
    .mask_i    (mask_q),
    .stat_i    (stat_w),
    .summ_i    (summ_w),
    .gen_i     (glb_en_q),
    .chen_i    (chen_q),
    .clr_wr_o  (clr_wr),
    .mask_wr_o (mask_wr),
    .chen_wr_o (chen_wr),
    .gcfg_wr_o (gcfg_wr),
    .rdata_o   (bus_rdata)
  );

  if (DATA_W > WE_W) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WE_W];
  end

  assign irq_o = glb_en_q & (|summ_w);

endmodule

// File: rtl/chirq_chk.sv
module chirq_chk
  import chirq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [NUM_CLASS*NCH-1:0]   ev_flat,
  input logic [NUM_CLASS*NCH-1:0]   raw_flat,
  input logic [NUM_CLASS*NCH-1:0]   mask_flat,
  input logic [NCH-1:0]             ev_xfer,
  input logic [NCH-1:0]             chen_q,
  input logic                       glb_en_q,
  input logic                       irq_o
);

  AST_RAW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_flat & $past(ev_flat)) == $past(ev_flat))); // R2

  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_sel && bus_wr)) |->
      ((raw_flat & $past(raw_flat)) == $past(raw_flat))); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_sel && bus_wr)) |-> $stable(mask_flat)); // R5

  AST_CHEN_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((chen_q & $past(ev_xfer)) == '0)); // R7

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_q |-> !irq_o); // R9

endmodule

bind chan_irq_ctrl chirq_chk #(.NCH(NCH)) u_chirq_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .ev_flat   (ev_bus),
  .raw_flat  (raw_q),
  .mask_flat (mask_q),
  .ev_xfer   (ev_xfer_done),
  .chen_q    (chen_q),
  .glb_en_q  (glb_en_q),
  .irq_o     (irq_o)
);

// File: tb/test_chan_irq_ctrl.sv
module test_chan_irq_ctrl;

  localparam logic [9:0] A_SUMM = 10'h360;
  localparam logic [9:0] A_GCFG = 10'h398;
  localparam logic [9:0] A_CHEN = 10'h3a0;

  function automatic logic [9:0] a_raw(input int k);  return 10'h2c0 + 10'(8 * k); endfunction
  function automatic logic [9:0] a_stat(input int k); return 10'h2e8 + 10'(8 * k); endfunction
  function automatic logic [9:0] a_mask(input int k); return 10'h310 + 10'(8 * k); endfunction
  function automatic logic [9:0] a_clr(input int k);  return 10'h338 + 10'(8 * k); endfunction

  logic            clk;
  logic            rst_n;
  logic            bus_sel;
  logic            bus_wr;
  logic [9:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [4:0][7:0] evb;
  logic            irq_o;

  int n_chk;
  int n_bad;
  bit done;

  chan_irq_ctrl i_chan_irq_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .ev_xfer_done  (evb[0]),
    .ev_block_done (evb[1]),
    .ev_src_txn    (evb[2]),
    .ev_dst_txn    (evb[3]),
    .ev_bus_err    (evb[4]),
    .irq_o         (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [9:0] a, input logic [31:0] exp);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk(req, what, bus_rdata, exp);
  endtask

  task automatic pulse(input int k, input logic [7:0] bits);
    evb[k] = bits;
    @(negedge clk);
    evb = '0;
  endtask

  task automatic write_with_ev(input logic [9:0] a, input logic [31:0] d, input int k, input logic [7:0] bits);
    evb[k] = bits;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    evb = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1", "irq after reset", {31'd0, irq_o}, 32'd0);
    rd_chk("R1", "raw xfer", a_raw(0), 32'h0);
    rd_chk("R1", "mask err", a_mask(4), 32'h0);
    rd_chk("R1", "chan enable", A_CHEN, 32'h0);
    rd_chk("R1", "summary", A_SUMM, 32'h0);
    rd_chk("R1", "global enable", A_GCFG, 32'h0);
  endtask

  task automatic t_raw_latch;
    pulse(1, 8'hA5);
    rd_chk("R2", "raw block latched while masked", a_raw(1), 32'hA5);
    rd_chk("R3", "status block all masked", a_stat(1), 32'h0);
    pulse(2, 8'h3C);
    pulse(3, 8'h81);
    rd_chk("R2", "raw src txn", a_raw(2), 32'h3C);
    rd_chk("R2", "raw dst txn", a_raw(3), 32'h81);
    rd_chk("R2", "raw xfer untouched", a_raw(0), 32'h0);
    rd_chk("R2", "raw block still held", a_raw(1), 32'hA5);
  endtask

  task automatic t_mask_we;
    bus_write(a_mask(1), 32'h0000_0FFF);
    rd_chk("R5", "mask low nibble enabled", a_mask(1), 32'h0F);
    bus_write(a_mask(1), 32'h0000_0100);
    rd_chk("R5", "mask one bit cleared", a_mask(1), 32'h0E);
    bus_write(a_mask(1), 32'hFFFF_00F0);
    rd_chk("R5", "mask no enable bits no change", a_mask(1), 32'h0E);
    rd_chk("R3", "status block raw and mask", a_stat(1), 32'h04);
    rd_chk("R8", "summary block only", A_SUMM, 32'h02);
    chk("R9", "irq held by global enable", {31'd0, irq_o}, 32'd0);
    bus_write(A_GCFG, 32'h1);
    rd_chk("R9", "global enable readback", A_GCFG, 32'h1);
    chk("R9", "irq with global enable", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_clear;
    bus_write(a_clr(1), 32'h04);
    rd_chk("R4", "raw after clear", a_raw(1), 32'hA1);
    rd_chk("R4", "clear word reads zero", a_clr(1), 32'h0);
    chk("R4", "irq after clear", {31'd0, irq_o}, 32'd0);
    write_with_ev(a_clr(1), 32'h03, 1, 8'h02);
    rd_chk("R4", "event beats clear", a_raw(1), 32'hA2);
    chk("R9", "irq from new event", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_chen;
    bus_write(A_CHEN, 32'h0000_FFFF);
    rd_chk("R6", "enable all", A_CHEN, 32'hFF);
    bus_write(A_CHEN, 32'hFFFF_0300);
    rd_chk("R6", "disable ch0 ch1 only", A_CHEN, 32'hFC);
    pulse(0, 8'h80);
    rd_chk("R7", "ch7 self clear", A_CHEN, 32'h7C);
    rd_chk("R2", "raw xfer ch7", a_raw(0), 32'h80);
    write_with_ev(A_CHEN, 32'h8080, 0, 8'h80);
    rd_chk("R7", "completion beats enable write", A_CHEN, 32'h7C);
    bus_write(A_CHEN, 32'h8080);
    rd_chk("R6", "re-enable ch7", A_CHEN, 32'hFC);
  endtask

  task automatic t_err_summary;
    bus_write(a_mask(4), 32'h0101);
    pulse(4, 8'h01);
    rd_chk("R8", "summary block and error", A_SUMM, 32'h12);
    bus_write(a_clr(1), 32'hFF);
    bus_write(a_clr(4), 32'hFF);
    rd_chk("R8", "summary empty", A_SUMM, 32'h0);
    chk("R9", "irq idle", {31'd0, irq_o}, 32'd0);
    bus_write(A_GCFG, 32'h0);
    pulse(4, 8'h01);
    rd_chk("R8", "summary error", A_SUMM, 32'h10);
    chk("R9", "irq gated off", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_unmapped;
    bus_write(10'h000, 32'hFFFF_FFFF);
    bus_write(10'h3a4, 32'hFFFF_FFFF);
    rd_chk("R10", "unmapped 0x000 reads zero", 10'h000, 32'h0);
    rd_chk("R10", "unmapped 0x3a4 reads zero", 10'h3a4, 32'h0);
    rd_chk("R10", "chan enable untouched", A_CHEN, 32'hFC);
    rd_chk("R10", "mask block untouched", a_mask(1), 32'h0E);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evb = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw_latch();
    t_mask_we();
    t_clear();
    t_chen();
    t_err_summary();
    t_unmapped();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule